// File: doc/BRIEF.md
# Cross-Processor Doorbell Flags

This block carries "message pending" signals between two processors, A and B. There is one channel for each direction, and the two channels are built the same way. In each channel one processor is the sender and the other is the receiver. The sender posts a message by writing ones into a 32-bit raise register. Each written one marks the matching pending bit. The receiver sees the same pending word through its inbox register. When it has dealt with a message, it writes ones to its retire register to clear those bits. The sender can also withdraw bits itself through a drop register. This is useful when it gives up waiting for a reply, or when the message needs no reply at all.

The four lowest bit positions are doorbells. A one written to one of them also sends a single-cycle interrupt pulse to the receiving processor. The other 28 positions only set the flag and send no interrupt. Each processor has its own simple register port: a write strobe, a word address, write data and combinational read data. Processor A is the sender on the A-to-B channel and the receiver on the B-to-A channel. Processor B is the reverse.

Top module: `xproc_doorbell`

## Requirements
- R1: After reset, every pending bit in both channels is 0, both interrupt outputs are 0, and every address on both ports reads 0.
- R2: A raise write (address 0) with a one in bit 0 to 3 sets that pending bit. It also drives the same bit of the receiver's interrupt output high for exactly the one cycle after the write edge.
- R3: A raise write with a one in bit 4 to 31 sets that pending bit and leaves the receiver's interrupt output at 0.
- R4: The sender reads the pending word of its outgoing channel at address 2.
- R5: The receiver's inbox read (address 3) always returns the same value as the sender's pending read for that channel.
- R6: A retire write (address 4) from the receiver clears every pending bit written as 1 in that channel.
- R7: A drop write (address 1) from the sender clears every pending bit written as 1 in its outgoing channel.
- R8: Clearing never suppresses or shortens an interrupt pulse, even when the clear lands in the same cycle as the raise. Re-raising a bit that is already pending pulses again.
- R9: When a raise and a clear target the same bit in the same cycle, the bit ends up set.
- R10: Bits written as 0 in raise, drop or retire leave the flags unchanged. Reads of addresses 0, 1, 4 and of the unused addresses 5 to 7 return 0.
- R11: Writes on one channel never change the pending word or the interrupt output of the other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_wr | input | 1 | Processor A write strobe |
| a_addr | input | 3 | Processor A word address |
| a_wdata | input | 32 | Processor A write data |
| a_rdata | output | 32 | Processor A read data (combinational) |
| a_irq | output | 4 | Interrupt pulses toward processor A |
| b_wr | input | 1 | Processor B write strobe |
| b_addr | input | 3 | Processor B word address |
| b_wdata | input | 32 | Processor B write data |
| b_rdata | output | 32 | Processor B read data (combinational) |
| b_irq | output | 4 | Interrupt pulses toward processor B |

## Verification
The assertions inside each channel check, on every cycle, that:
- every interrupt pulse traces back to a raise write one cycle earlier;
- every raise write produces its pulse whatever clears happen alongside it;
- raised bits survive a simultaneous clear;
- cleared bits go to zero when no raise accompanies them;
- an idle cycle leaves the flags untouched.

Three things can only be shown by the bench's scenarios, because they involve the address decode and both ports together:
- that the inbox read always mirrors the sender's pending read;
- that write-only and unused addresses read as zero;
- that the two channels stay isolated from each other.

// File: rtl/xpf_pkg.sv
package xpf_pkg;
  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    ADDR_RAISE  = 3'd0,
    ADDR_DROP   = 3'd1,
    ADDR_PEND   = 3'd2,
    ADDR_INBOX  = 3'd3,
    ADDR_RETIRE = 3'd4
  } xpf_addr_e;
endpackage

// File: rtl/xpf_rst_sync.sv
module xpf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/xpf_port.sv
module xpf_port
  import xpf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic                  wr,
  input  logic [DATA_W-1:0]     out_pend,
  input  logic [DATA_W-1:0]     in_pend,
  output logic                  raise_we,
  output logic                  drop_we,
  output logic                  retire_we,
  output logic [DATA_W-1:0]     rdata
);
  always_comb begin
    raise_we  = wr && (addr == ADDR_RAISE);
    drop_we   = wr && (addr == ADDR_DROP);
    retire_we = wr && (addr == ADDR_RETIRE);
  end

  always_comb begin
    case (addr)
      ADDR_PEND:  rdata = out_pend;
      ADDR_INBOX: rdata = in_pend;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/xpf_channel.sv
module xpf_channel #(
  parameter int DATA_W = 32,
  parameter int IRQ_N  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raise_we,
  input  logic [DATA_W-1:0] raise_data,
  input  logic              drop_we,
  input  logic [DATA_W-1:0] drop_data,
  input  logic              retire_we,
  input  logic [DATA_W-1:0] retire_data,
  output logic [DATA_W-1:0] pend_o,
  output logic [IRQ_N-1:0]  irq_o
);
  logic [DATA_W-1:0] raise_mask, drop_mask, retire_mask, clr_mask;
  logic [DATA_W-1:0] pend_q, pend_d;
  logic              pend_en;
  logic [IRQ_N-1:0]  irq_q, irq_d;

  always_comb begin
    raise_mask  = raise_we  ? raise_data  : '0;
    drop_mask   = drop_we   ? drop_data   : '0;
    retire_mask = retire_we ? retire_data : '0;
    clr_mask    = drop_mask | retire_mask;
    pend_en     = raise_we | drop_we | retire_we;
    pend_d      = (pend_q & ~clr_mask) | raise_mask;
    irq_d       = raise_mask[IRQ_N-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

  assign pend_o = pend_q;
  assign irq_o  = irq_q;

  AST_IRQ_NEEDS_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_o) |-> ($past(raise_we) && ((irq_o & ~$past(raise_data[IRQ_N-1:0])) == '0))); // R2
  AST_IRQ_NOT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    raise_we |=> (irq_o == $past(raise_data[IRQ_N-1:0]))); // R8
  AST_RAISE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    raise_we |=> ((pend_o & $past(raise_data)) == $past(raise_data))); // R9
  AST_RETIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_we && !raise_we) |=> ((pend_o & $past(retire_data)) == '0)); // R6
  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_we && !raise_we) |=> ((pend_o & $past(drop_data)) == '0)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(raise_we || drop_we || retire_we) |=> $stable(pend_o)); // R10
endmodule

// File: rtl/xproc_doorbell.sv
module xproc_doorbell
  import xpf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IRQ_N  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  a_wr,
  input  logic [REG_ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0]     a_wdata,
  output logic [DATA_W-1:0]     a_rdata,
  output logic [IRQ_N-1:0]      a_irq,
  input  logic                  b_wr,
  input  logic [REG_ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0]     b_wdata,
  output logic [DATA_W-1:0]     b_rdata,
  output logic [IRQ_N-1:0]      b_irq
);
  logic              rst_n_s;
  logic              a_raise, a_drop, a_retire;
  logic              b_raise, b_drop, b_retire;
  logic [DATA_W-1:0] ab_pend, ba_pend;

  xpf_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_n_s)
  );

  xpf_port #(.DATA_W(DATA_W)) u_port_a (
    .addr(a_addr), .wr(a_wr), .out_pend(ab_pend), .in_pend(ba_pend),
    .raise_we(a_raise), .drop_we(a_drop), .retire_we(a_retire), .rdata(a_rdata)
  );

  xpf_port #(.DATA_W(DATA_W)) u_port_b (
    .addr(b_addr), .wr(b_wr), .out_pend(ba_pend), .in_pend(ab_pend),
    .raise_we(b_raise), .drop_we(b_drop), .retire_we(b_retire), .rdata(b_rdata)
  );

  xpf_channel #(.DATA_W(DATA_W), .IRQ_N(IRQ_N)) u_ch_ab (
    .clk(clk), .rst_n(rst_n_s),
    .raise_we(a_raise), .raise_data(a_wdata),
    .drop_we(a_drop), .drop_data(a_wdata),
    .retire_we(b_retire), .retire_data(b_wdata),
    .pend_o(ab_pend), .irq_o(b_irq)
  );

  xpf_channel #(.DATA_W(DATA_W), .IRQ_N(IRQ_N)) u_ch_ba (
    .clk(clk), .rst_n(rst_n_s),
    .raise_we(b_raise), .raise_data(b_wdata),
    .drop_we(b_drop), .drop_data(b_wdata),
    .retire_we(a_retire), .retire_data(a_wdata),
    .pend_o(ba_pend), .irq_o(a_irq)
  );
endmodule

// File: tb/test_xproc_doorbell.sv
`timescale 1ns/1ps
module test_xproc_doorbell;
  logic        clk;
  logic        rst_n;
  logic        a_wr, b_wr;
  logic [2:0]  a_addr, b_addr;
  logic [31:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic [3:0]  a_irq, b_irq;
  int checks = 0;
  int errors = 0;

  xproc_doorbell i_xproc_doorbell (
    .clk(clk), .rst_n(rst_n),
    .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq(a_irq),
    .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq(b_irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr1(input int side, input logic [2:0] adr, input logic [31:0] d);
    @(negedge clk);
    if (side == 0) begin a_wr = 1'b1; a_addr = adr; a_wdata = d; end
    else           begin b_wr = 1'b1; b_addr = adr; b_wdata = d; end
    @(negedge clk);
    a_wr = 1'b0; b_wr = 1'b0;
  endtask

  task automatic rd(input int side, input logic [2:0] adr, output logic [31:0] d);
    if (side == 0) a_addr = adr; else b_addr = adr;
    #1;
    d = (side == 0) ? a_rdata : b_rdata;
  endtask

  function automatic logic [3:0] irq_of(input int side);
    return (side == 0) ? a_irq : b_irq;
  endfunction

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; a_wr = 1'b0; b_wr = 1'b0;
    a_addr = '0; b_addr = '0; a_wdata = '0; b_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 a_irq", {28'd0, a_irq}, 32'd0);
    chk("R1 b_irq", {28'd0, b_irq}, 32'd0);
    for (int ad = 0; ad < 8; ad++) begin
      rd(0, 3'(ad), v); chk("R1 read A", v, 32'd0);
      rd(1, 3'(ad), v); chk("R1 read B", v, 32'd0);
    end

    // Sweep every bit in both directions
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 32; i++) begin
        logic [31:0] m;
        logic [3:0]  exp_irq;
        int r;
        r = 1 - s;
        m = 32'h1 << i;
        exp_irq = (i < 4) ? m[3:0] : 4'd0;
        wr1(s, 3'd0, m);
        chk((i < 4) ? "R2 pulse" : "R3 no pulse", {28'd0, irq_of(r)}, {28'd0, exp_irq});
        chk("R11 sender irq quiet", {28'd0, irq_of(s)}, 32'd0);
        rd(s, 3'd2, v); chk("R4 pending", v, m);
        rd(r, 3'd3, v); chk("R5 inbox mirror", v, m);
        rd(r, 3'd2, v); chk("R11 other channel", v, 32'd0);
        @(negedge clk);
        chk("R2 single cycle", {28'd0, irq_of(r)}, 32'd0);
        if (i % 2 == 0) begin
          wr1(r, 3'd4, m);
          rd(s, 3'd2, v); chk("R6 retire", v, 32'd0);
          rd(r, 3'd3, v); chk("R6 inbox cleared", v, 32'd0);
        end else begin
          wr1(s, 3'd1, m);
          rd(s, 3'd2, v); chk("R7 drop", v, 32'd0);
          rd(r, 3'd3, v); chk("R7 inbox cleared", v, 32'd0);
        end
      end
    end

    // Multi-bit patterns, zero writes, write-only reads
    wr1(0, 3'd0, 32'hA5A5_0F0F);
    chk("R2 multi pulse", {28'd0, b_irq}, 32'h0000_000F);
    wr1(0, 3'd0, 32'h0);
    chk("R10 zero raise no pulse", {28'd0, b_irq}, 32'd0);
    wr1(0, 3'd1, 32'h0);
    wr1(1, 3'd4, 32'h0);
    rd(0, 3'd2, v); chk("R10 zeros keep flags", v, 32'hA5A5_0F0F);
    wr1(1, 3'd4, 32'h0000_0F00);
    rd(1, 3'd3, v); chk("R6 partial retire", v, 32'hA5A5_000F);
    wr1(0, 3'd1, 32'hA000_0000);
    rd(0, 3'd2, v); chk("R7 partial drop", v, 32'h05A5_000F);
    foreach (v[k]) begin end
    rd(0, 3'd0, v); chk("R10 raise reads zero", v, 32'd0);
    rd(0, 3'd1, v); chk("R10 drop reads zero", v, 32'd0);
    rd(1, 3'd4, v); chk("R10 retire reads zero", v, 32'd0);
    for (int ad = 5; ad < 8; ad++) begin
      rd(0, 3'(ad), v); chk("R10 unused A", v, 32'd0);
      rd(1, 3'(ad), v); chk("R10 unused B", v, 32'd0);
    end
    rd(1, 3'd2, v); chk("R11 B->A untouched", v, 32'd0);

    // Same-cycle raise and retire: raise wins, pulse survives, re-raise pulses
    @(negedge clk);
    a_wr = 1'b1; a_addr = 3'd0; a_wdata = 32'h0010_0002;
    b_wr = 1'b1; b_addr = 3'd4; b_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    a_wr = 1'b0; b_wr = 1'b0;
    chk("R8 pulse despite clear", {28'd0, b_irq}, 32'h0000_0002);
    rd(0, 3'd2, v); chk("R9 raise wins", v, 32'h0010_0002);
    rd(1, 3'd3, v); chk("R5 mirror after race", v, 32'h0010_0002);

    // Same-cycle on reverse channel: B raises, A retires
    @(negedge clk);
    b_wr = 1'b1; b_addr = 3'd0; b_wdata = 32'h0000_0009;
    a_wr = 1'b1; a_addr = 3'd4; a_wdata = 32'h0000_0001;
    @(negedge clk);
    a_wr = 1'b0; b_wr = 1'b0;
    chk("R8 reverse pulse", {28'd0, a_irq}, 32'h0000_0009);
    rd(1, 3'd2, v); chk("R9 reverse raise wins", v, 32'h0000_0009);
    rd(0, 3'd2, v); chk("R11 A->B unaffected", v, 32'h0010_0002);

    // Clear right after raise keeps the pulse already issued
    wr1(0, 3'd0, 32'h0000_0004);
    chk("R8 pulse before clear", {28'd0, b_irq}, 32'h0000_0004);
    wr1(0, 3'd1, 32'h0000_0004);
    rd(1, 3'd3, v); chk("R7 cleared after pulse", v, 32'h0010_0002);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule